// File: doc/BRIEF.md
# Four-Register Minimal Instruction Processor

This block is a small multi-cycle processor core. It has four 8-bit general registers, a program counter and a single word-addressed memory port. It fetches instructions from the memory port and executes them. There are eight operations: load from memory, store to memory, register copy, register complement, add, subtract, unconditional jump and conditional jump. The conditional jump is steered by an external condition input. The surrounding system supplies a memory with a one-cycle read latency. This memory holds both the program and the data.

Each instruction is one word. The memory and jump forms are followed by a second word that carries an address. Register forms take three cycles: fetch, decode and execute. Two-word forms take four cycles, because they add a cycle to pick up the address word. The program counter moves past one or two words to match the instruction length. A conditional jump that is not taken moves past both words.

Top module: `tinyRegCpu`

## Requirements
- R1: Instruction word layout: bit 7 is zero, bits [6:5] are the opcode, bit 4 is the variant bit, bits [3:2] are the destination selector and bits [1:0] are the source selector. Opcodes 0 and 3 are followed by an address word. After reset, fetch starts at address 0. A register form occupies 3 clock cycles (fetch, decode, execute). A two-word form occupies 4 clock cycles. The memory read returns data one cycle after the address is presented.
- R2: Opcode 0 with variant 0 writes the memory word at the address word into the destination register. The PC then moves forward by 2. The other registers are left unchanged.
- R3: Opcode 0 with variant 1 raises the write strobe for exactly one cycle, in the execute cycle. In that cycle the address output is the address word and the write data is the source register. The PC moves forward by 2.
- R4: Opcode 1 copies the source register into the destination (variant 0), or writes its bitwise complement there (variant 1). The PC moves forward by 1.
- R5: Opcode 2 sets destination = destination + source (variant 0), or destination = destination − source (variant 1). Both wrap modulo 256. The PC moves forward by 1.
- R6: Opcode 3 with variant 0 loads the PC with the address word, whatever the condition input is.
- R7: Opcode 3 with variant 1 loads the PC with the address word when the condition input is 1 in its execute cycle. Otherwise the PC moves forward by 2, past the address word.
- R8: Synchronous reset clears the PC and all four registers to zero. While reset is held, the write strobe is low and the address output is 0.
- R9: The write strobe is low in every cycle other than the execute cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond | input | 1 | Condition for the conditional jump |
| memRData | input | 8 | Read data, valid one cycle after its address |
| memAddr | output | 8 | Memory address for reads and writes |
| memWData | output | 8 | Store data |
| memWe | output | 1 | Write strobe |

## Verification
The registers and the program counter are internal, so a wrong internal value shows at the ports only through what the processor does next. A corrupted register shows up as the data word of the next store that reads it. A wrong PC step or a wrong jump decision shows up at once, as the address output in the following fetch cycle. A missing or extra store shows up as the write strobe in the very cycle it occurs. Each test therefore preloads all four registers, executes one instruction, and dumps every register back to memory. It also traces the address output cycle by cycle around the instruction under test.

// File: rtl/tinyRegCpuPkg.sv
package tinyRegCpuPkg;

  typedef enum logic [1:0] {
    OP_MEM    = 2'd0,
    OP_MOVE   = 2'd1,
    OP_ARITH  = 2'd2,
    OP_BRANCH = 2'd3
  } opCode_e;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_INC1 = 2'd1,
    PC_INC2 = 2'd2,
    PC_JUMP = 2'd3
  } pcSel_e;

  typedef enum logic [1:0] {
    AD_PC    = 2'd0,
    AD_PC1   = 2'd1,
    AD_RDATA = 2'd2,
    AD_AWORD = 2'd3
  } addrSel_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_AWORD  = 2'd2,
    ST_EXEC   = 2'd3
  } cpuState_e;

  typedef struct packed {
    logic     irLoad;
    logic     awLoad;
    logic     regWe;
    logic     memWe;
    pcSel_e   pcSel;
    addrSel_e addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/tinyRegCpuCtrl.sv
module tinyRegCpuCtrl
  import tinyRegCpuPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cond,
  input  logic [1:0]  fetchOp,
  input  logic [1:0]  irOp,
  input  logic        irB,
  output ctrlStrobe_t strobe,
  output logic        inExec
);

  cpuState_e state, stateNext;
  opCode_e   curOp;
  opCode_e   newOp;

  assign curOp  = opCode_e'(irOp);
  assign newOp  = opCode_e'(fetchOp);
  assign inExec = (state == ST_EXEC);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    strobe    = '{irLoad: 1'b0, awLoad: 1'b0, regWe: 1'b0, memWe: 1'b0,
                  pcSel: PC_HOLD, addrSel: AD_PC};
    stateNext = state;
    if (!rst) begin
      case (state)
        ST_FETCH: begin
          stateNext = ST_DECODE;
        end
        ST_DECODE: begin
          strobe.irLoad  = 1'b1;
          strobe.addrSel = AD_PC1;
          stateNext = (newOp == OP_MEM || newOp == OP_BRANCH) ? ST_AWORD : ST_EXEC;
        end
        ST_AWORD: begin
          strobe.awLoad  = 1'b1;
          strobe.addrSel = AD_RDATA;
          stateNext = ST_EXEC;
        end
        default: begin
          stateNext = ST_FETCH;
          case (curOp)
            OP_MEM: begin
              strobe.pcSel = PC_INC2;
              if (irB) begin
                strobe.memWe   = 1'b1;
                strobe.addrSel = AD_AWORD;
              end else begin
                strobe.regWe = 1'b1;
              end
            end
            OP_MOVE, OP_ARITH: begin
              strobe.regWe = 1'b1;
              strobe.pcSel = PC_INC1;
            end
            default: begin
              strobe.pcSel = (!irB || cond) ? PC_JUMP : PC_INC2;
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/tinyRegCpuDatapath.sv
module tinyRegCpuDatapath
  import tinyRegCpuPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [1:0]        fetchOp,
  output logic [1:0]        irOp,
  output logic              irB,
  output logic [DATA_W-1:0] pcVal,
  output logic [DATA_W-1:0] awVal
);

  localparam int SEL_W  = $clog2(NUM_REGS);
  localparam int B_POS  = 2 * SEL_W;
  localparam int OP_LSB = B_POS + 1;

  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [SEL_W-1:0]  selDst, selSrc;
  logic [DATA_W-1:0] dstVal, srcVal, wrData;

  assign fetchOp = memRData[OP_LSB +: 2];
  assign irOp    = ir[OP_LSB +: 2];
  assign irB     = ir[B_POS];
  assign selDst  = ir[SEL_W +: SEL_W];
  assign selSrc  = ir[0 +: SEL_W];
  assign dstVal  = regFile[selDst];
  assign srcVal  = regFile[selSrc];
  assign memWData = srcVal;

  always_comb begin
    case (opCode_e'(irOp))
      OP_MEM:  wrData = memRData;
      OP_MOVE: wrData = irB ? ~srcVal : srcVal;
      default: wrData = irB ? (dstVal - srcVal) : (dstVal + srcVal);
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst)
        regFile[g] <= '0;
      else if (strobe.regWe && selDst == SEL_W'(g))
        regFile[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir    <= '0;
      awVal <= '0;
      pcVal <= '0;
    end else begin
      if (strobe.irLoad) ir    <= memRData;
      if (strobe.awLoad) awVal <= memRData;
      case (strobe.pcSel)
        PC_INC1: pcVal <= pcVal + DATA_W'(1);
        PC_INC2: pcVal <= pcVal + DATA_W'(2);
        PC_JUMP: pcVal <= awVal;
        default: pcVal <= pcVal;
      endcase
    end
  end

  always_comb begin
    case (strobe.addrSel)
      AD_PC1:   memAddr = pcVal + DATA_W'(1);
      AD_RDATA: memAddr = memRData;
      AD_AWORD: memAddr = awVal;
      default:  memAddr = pcVal;
    endcase
  end

endmodule

// File: rtl/tinyRegCpu.sv
module tinyRegCpu
  import tinyRegCpuPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cond,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memWe
);

  ctrlStrobe_t       strobe;
  logic [1:0]        fetchOp, irOp;
  logic              irB, inExec;
  logic [DATA_W-1:0] pcVal, awVal;

  tinyRegCpuCtrl u_ctrl (
    .clk(clk), .rst(rst), .cond(cond),
    .fetchOp(fetchOp), .irOp(irOp), .irB(irB),
    .strobe(strobe), .inExec(inExec)
  );

  tinyRegCpuDatapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData),
    .fetchOp(fetchOp), .irOp(irOp), .irB(irB),
    .pcVal(pcVal), .awVal(awVal)
  );

  assign memWe = strobe.memWe;

endmodule

// File: rtl/tinyRegCpuChecker.sv
module tinyRegCpuChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cond,
  input logic              memWe,
  input logic              inExec,
  input logic [1:0]        irOp,
  input logic              irB,
  input logic [DATA_W-1:0] pcVal,
  input logic [DATA_W-1:0] awVal
);

  a_r8_pc_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pcVal == '0));

  a_r2_mem_step: assert property (@(posedge clk) disable iff (rst)
    (inExec && irOp == 2'd0) |=> (pcVal == $past(pcVal) + DATA_W'(2)));

  a_r4_r5_reg_step: assert property (@(posedge clk) disable iff (rst)
    (inExec && (irOp == 2'd1 || irOp == 2'd2)) |=> (pcVal == $past(pcVal) + DATA_W'(1)));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    (inExec && irOp == 2'd3 && !irB) |=> (pcVal == $past(awVal)));

  a_r7_taken: assert property (@(posedge clk) disable iff (rst)
    (inExec && irOp == 2'd3 && irB && cond) |=> (pcVal == $past(awVal)));

  a_r7_skip: assert property (@(posedge clk) disable iff (rst)
    (inExec && irOp == 2'd3 && irB && !cond) |=> (pcVal == $past(pcVal) + DATA_W'(2)));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);

  a_r9_strobe_in_exec: assert property (@(posedge clk) disable iff (rst)
    memWe |-> inExec);

endmodule

bind tinyRegCpu tinyRegCpuChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cond(cond), .memWe(memWe), .inExec(inExec),
  .irOp(irOp), .irB(irB), .pcVal(pcVal), .awVal(awVal)
);

// File: tb/test_tinyRegCpu.sv
`timescale 1ns/1ps
module test_tinyRegCpu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cond = 1'b0;
  logic [7:0] memRData = '0;
  logic [7:0] memAddr, memWData;
  logic       memWe;

  logic [7:0] mem [256];
  logic [7:0] addrTrace [64];
  int nChecks = 0;
  int nFails  = 0;
  int weCnt, firstWe;
  logic [7:0] firstWeAddr, firstWeData;

  always #2 clk = ~clk;

  tinyRegCpu i_tinyRegCpu (
    .clk(clk), .rst(rst), .cond(cond), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData), .memWe(memWe)
  );

  always @(posedge clk) begin
    memRData <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWData;
  end

  // {op, variant, dst, src, R0, R1, R2, R3}
  localparam logic [38:0] VECS [8] = '{
    {2'd2, 1'b0, 2'd3, 2'd2, 8'h10, 8'h20, 8'h30, 8'h40},
    {2'd2, 1'b1, 2'd1, 2'd0, 8'h09, 8'h05, 8'h77, 8'h01},
    {2'd1, 1'b0, 2'd0, 2'd3, 8'h01, 8'h02, 8'h03, 8'hC4},
    {2'd1, 1'b1, 2'd2, 2'd1, 8'h00, 8'h5A, 8'h13, 8'h99},
    {2'd2, 1'b0, 2'd1, 2'd1, 8'h0F, 8'h81, 8'h3C, 8'h42},
    {2'd2, 1'b1, 2'd2, 2'd2, 8'hAB, 8'hCD, 8'hEF, 8'h12},
    {2'd2, 1'b0, 2'd0, 2'd3, 8'hC8, 8'h11, 8'h22, 8'h64},
    {2'd1, 1'b1, 2'd3, 2'd3, 8'h31, 8'h32, 8'h33, 8'hF0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input logic [1:0] op, input logic b,
                                     input logic [1:0] a1, input logic [1:0] a2);
    return {1'b0, op, b, a1, a2};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic doReset();
    rst = 1'b1;
    step();
    step();
    check("R8 strobe in reset", {7'd0, memWe}, 8'h00);
    check("R8 address in reset", memAddr, 8'h00);
    rst = 1'b0;
  endtask

  task automatic runProg(input int n);
    weCnt = 0;
    firstWe = -1;
    for (int c = 0; c < n; c++) begin
      if (c < 64) addrTrace[c] = memAddr;
      if (memWe) begin
        weCnt++;
        if (firstWe < 0) begin
          firstWe = c;
          firstWeAddr = memAddr;
          firstWeData = memWData;
        end
      end
      step();
    end
  endtask

  task automatic preload(input logic [7:0] r0, input logic [7:0] r1,
                         input logic [7:0] r2, input logic [7:0] r3);
    for (int i = 0; i < 4; i++) begin
      mem[2*i]   = enc(2'd0, 1'b0, 2'(i), 2'd0);
      mem[2*i+1] = 8'hF0 + 8'(i);
    end
    mem[8'hF0] = r0; mem[8'hF1] = r1; mem[8'hF2] = r2; mem[8'hF3] = r3;
  endtask

  task automatic jumpTest(input logic b, input logic c, input logic taken, input string tag);
    clearMem();
    preload(8'h11, 8'h22, 8'h33, 8'h44);
    mem[8]  = enc(2'd3, b, 2'd0, 2'd0); mem[9]  = 8'd30;
    mem[10] = enc(2'd0, 1'b0, 2'd0, 2'd0); mem[11] = 8'hF4;
    mem[12] = enc(2'd3, 1'b0, 2'd0, 2'd0); mem[13] = 8'd30;
    mem[30] = enc(2'd0, 1'b1, 2'd0, 2'd0); mem[31] = 8'hE0;
    mem[32] = enc(2'd3, 1'b0, 2'd0, 2'd0); mem[33] = 8'd32;
    mem[8'hF4] = 8'hAA;
    mem[8'hE0] = 8'hEE;
    cond = c;
    doReset();
    runProg(60);
    check({tag, " next fetch"}, addrTrace[20], taken ? 8'd30 : 8'd10);
    check({tag, " result"}, mem[8'hE0], taken ? 8'h11 : 8'hAA);
    cond = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [38:0] v;
    logic [1:0]  op, a1, a2;
    logic        b;
    logic [7:0]  expR [4];

    @(negedge clk);

    // Table of register-form vectors
    for (int k = 0; k < 8; k++) begin
      v  = VECS[k];
      op = v[38:37]; b = v[36]; a1 = v[35:34]; a2 = v[33:32];
      for (int i = 0; i < 4; i++) expR[i] = v[31-8*i -: 8];
      clearMem();
      preload(expR[0], expR[1], expR[2], expR[3]);
      mem[8] = enc(op, b, a1, a2);
      for (int i = 0; i < 4; i++) begin
        mem[9+2*i]  = enc(2'd0, 1'b1, 2'd0, 2'(i));
        mem[10+2*i] = 8'hE0 + 8'(i);
        mem[8'hE0 + 8'(i)] = 8'hEE;
      end
      mem[17] = enc(2'd3, 1'b0, 2'd0, 2'd0);
      mem[18] = 8'd17;
      doReset();
      runProg(60);
      if (op == 2'd1) expR[a1] = b ? ~expR[a2] : expR[a2];
      else            expR[a1] = b ? (expR[a1] - expR[a2]) : (expR[a1] + expR[a2]);
      for (int i = 0; i < 4; i++) begin
        if (2'(i) == a1)
          check(op == 2'd1 ? "R4 move/complement dest" : "R5 add/sub dest",
                mem[8'hE0 + 8'(i)], expR[i]);
        else
          check("R2 loaded reg kept", mem[8'hE0 + 8'(i)], expR[i]);
      end
      check("R9 strobe count", 8'(weCnt), 8'd4);
      if (k == 0) begin
        check("R1 fetch addr c0", addrTrace[0], 8'h00);
        check("R1 word addr c1", addrTrace[1], 8'h01);
        check("R2 operand addr c2", addrTrace[2], 8'hF0);
        check("R2 next fetch c4", addrTrace[4], 8'h02);
        check("R1 reg op fetch c16", addrTrace[16], 8'h08);
        check("R4 R5 next fetch c19", addrTrace[19], 8'h09);
        check("R3 strobe cycle", 8'(firstWe), 8'd22);
        check("R3 store addr", firstWeAddr, 8'hE0);
        check("R3 store data", firstWeData, 8'h10);
      end
    end

    // Jumps
    jumpTest(1'b0, 1'b0, 1'b1, "R6 jump cond=0");
    jumpTest(1'b0, 1'b1, 1'b1, "R6 jump cond=1");
    jumpTest(1'b1, 1'b1, 1'b1, "R7 cjump taken");
    jumpTest(1'b1, 1'b0, 1'b0, "R7 cjump skip");

    // Reset clears registers (left nonzero by previous test)
    clearMem();
    for (int i = 0; i < 4; i++) begin
      mem[2*i]   = enc(2'd0, 1'b1, 2'd0, 2'(i));
      mem[2*i+1] = 8'hE0 + 8'(i);
      mem[8'hE0 + 8'(i)] = 8'hEE;
    end
    mem[8] = enc(2'd3, 1'b0, 2'd0, 2'd0);
    mem[9] = 8'd8;
    doReset();
    runProg(40);
    for (int i = 0; i < 4; i++) check("R8 reg cleared", mem[8'hE0 + 8'(i)], 8'h00);
    check("R9 strobe count halt", 8'(weCnt), 8'd4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule